// File: doc/BRIEF.md
# Priority Reschedule Interrupt Generator

This block helps a guest operating system keep its most urgent work running across a set of hardware threads. Each thread has a priority value held in the block. Software also writes a threshold that holds the priority of the most urgent task that is waiting for a thread. Priorities are 9 bits wide, and a larger number means a less urgent task.

When the scheduler assist is enabled and any thread is running at a priority worse than the threshold, the block raises a one-cycle reschedule interrupt. It also latches the lowest-numbered offending thread as a suggested target and sets a sticky pending flag. At the same time it reloads the threshold with the idle code 0x1ff. No priority can be worse than 0x1ff, so the interrupt stays quiet until software writes a new threshold.

Software reaches every register through one write port and one combinational read port.

Top module: `resched_irq`

## Requirements
- R1: After reset the enable bit, the pending flag and the interrupt output are 0. The threshold reads 0x1ff, every thread priority reads 0 and the target output is 0.
- R2: Register map on `wr_addr`/`rd_addr`:
  - Address 0 is control. Bit 0 is the enable bit, read/write. Bit 1 is the pending flag; it reads back its state, and writing 1 to it clears it.
  - Address 1 is the threshold.
  - Address 2+i is the priority of thread i.
  - Every write takes effect at the clock edge where `wr_en` is high. Reads are combinational.
- R3: When enable is 1 and some thread priority is numerically greater than the threshold, `irq` is high for exactly one cycle. The cycle is the one after the edge at which the state that meets this condition was written.
- R4: A thread whose priority equals or is below the threshold never causes an interrupt.
- R5: While enable is 0 no interrupt fires. Setting enable while the condition already holds fires the interrupt one cycle later.
- R6: At the edge where the interrupt fires, the threshold is reloaded with 0x1ff. No further interrupt fires until software writes a new threshold.
- R7: Each interrupt sets the pending flag (`pending` and control bit 1). The flag holds until software writes control with bit 1 set. If a clear arrives at the same edge as an interrupt, the flag is set.
- R8: At each interrupt, `tgt_thread` takes the index of the lowest-numbered thread whose priority was worse than the threshold. It holds that value until the next interrupt.
- R9: If software writes the threshold at the same edge as an interrupt, the reload to 0x1ff wins and the written value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Write register address |
| wr_data | input | PW (9) | Write data |
| rd_addr | input | AW (3) | Read register address |
| rd_data | output | PW (9) | Combinational read data |
| irq | output | 1 | One-cycle reschedule interrupt |
| pending | output | 1 | Sticky interrupt-pending flag |
| tgt_thread | output | TW (2) | Suggested target thread, latched at each interrupt |

## Verification
A register write becomes visible on `rd_data` right after its edge. The interrupt, the pending flag, the target index and the threshold reload all appear one edge after the state that causes them.

The bench drives inputs on the falling edge and reads outputs on the falling edge that follows. For each write it checks the falling edge after the write edge (expected quiet) and then the next one (expected pulse). It checks one more falling edge after that to confirm the pulse has ended.

The same-edge races in R7 and R9 are set up with back-to-back writes. The second write then lands exactly on the edge where the interrupt fires.

// File: rtl/resched_irq.sv
module resched_irq #(
  parameter int NTHR = 4,
  parameter int PW   = 9,
  localparam int AW  = $clog2(NTHR + 2),
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [PW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rd_data,
  output logic          irq,
  output logic          pending,
  output logic [TW-1:0] tgt_thread
);
  localparam logic [PW-1:0] IDLE = '1;

  logic          en_q, pend_q, irq_q;
  logic [PW-1:0] best_q;
  logic [PW-1:0] prio_q [NTHR];
  logic [NTHR-1:0] worse;
  logic [TW-1:0] first_idx, tgt_q;

  wire wr_ctl  = wr_en && (wr_addr == AW'(0));
  wire wr_best = wr_en && (wr_addr == AW'(1));
  wire fire    = en_q && (|worse);

  for (genvar g = 0; g < NTHR; g++) begin : g_cmp
    assign worse[g] = prio_q[g] > best_q;
  end

  always_comb begin
    first_idx = '0;
    for (int i = NTHR - 1; i >= 0; i--)
      if (worse[i]) first_idx = TW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      best_q <= IDLE;
      tgt_q  <= '0;
      for (int i = 0; i < NTHR; i++) prio_q[i] <= '0;
    end else begin
      irq_q <= fire;
      if (wr_ctl) en_q <= wr_data[0];
      if (fire) best_q <= IDLE;
      else if (wr_best) best_q <= wr_data;
      if (fire) pend_q <= 1'b1;
      else if (wr_ctl && wr_data[1]) pend_q <= 1'b0;
      if (fire) tgt_q <= first_idx;
      for (int i = 0; i < NTHR; i++)
        if (wr_en && wr_addr == AW'(i + 2)) prio_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(0)) begin
      rd_data[0] = en_q;
      rd_data[1] = pend_q;
    end else if (rd_addr == AW'(1)) begin
      rd_data = best_q;
    end else begin
      for (int i = 0; i < NTHR; i++)
        if (rd_addr == AW'(i + 2)) rd_data = prio_q[i];
    end
  end

  assign irq        = irq_q;
  assign pending    = pend_q;
  assign tgt_thread = tgt_q;

  assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  assert_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(en_q));
  assert_reload_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> best_q == IDLE);
  assert_pending_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> pend_q);
  assert_tgt_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> $stable(tgt_q));
endmodule

// File: tb/tb_resched_irq.sv
module tb_resched_irq;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [8:0] wr_data = 0;
  logic [8:0] rd_data;
  logic irq, pending;
  logic [1:0] tgt_thread;
  int total = 0, bad = 0;
  bit finished = 0;

  resched_irq dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .pending(pending), .tgt_thread(tgt_thread));

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 9'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(string tag, int a, int exp);
    rd_addr = 3'(a); #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0); chk("R1 pending", pending, 0);
    chk("R1 tgt", tgt_thread, 0);
    rd("R1 ctrl", 0, 0); rd("R1 best", 1, 9'h1ff); rd("R1 prio0", 2, 0);
  endtask

  task automatic t_regs;
    for (int i = 0; i < 4; i++) wr(2 + i, 16 * (i + 1));
    for (int i = 0; i < 4; i++) rd("R2 prio", 2 + i, 16 * (i + 1));
  endtask

  task automatic t_disabled;
    wr(1, 5);
    step; chk("R5 no irq while disabled", irq, 0);
    step; chk("R5 no irq while disabled", irq, 0);
    rd("R5 best kept", 1, 5);
  endtask

  task automatic t_equal;
    wr(1, 9'h040); wr(0, 1);
    step; chk("R4 equal no irq", irq, 0);
    step; chk("R4 equal no irq", irq, 0);
    rd("R2 ctrl enabled", 0, 1);
  endtask

  task automatic t_fire;
    wr(1, 9'h025);
    chk("R3 not yet", irq, 0);
    step; chk("R3 irq pulse", irq, 1);
    chk("R8 tgt lowest", tgt_thread, 2);
    rd("R6 reload", 1, 9'h1ff);
    chk("R7 pending set", pending, 1);
    rd("R7 ctrl pending", 0, 3);
    step; chk("R3 pulse ends", irq, 0);
    step; step; chk("R6 no refire", irq, 0);
    wr(0, 3);
    chk("R7 cleared", pending, 0);
    chk("R8 tgt held", tgt_thread, 2);
  endtask

  task automatic t_targets;
    wr(1, 0); step; chk("R3 irq", irq, 1); chk("R8 tgt0", tgt_thread, 0);
    step; wr(2, 0); wr(1, 5);
    step; chk("R3 irq", irq, 1); chk("R8 tgt1", tgt_thread, 1);
    step; wr(0, 3);
  endtask

  task automatic t_race_best;
    wr(1, 5); wr(1, 9'h020);
    chk("R9 irq", irq, 1);
    rd("R9 reload wins", 1, 9'h1ff);
    step; chk("R9 no second irq", irq, 0);
    wr(0, 3);
  endtask

  task automatic t_race_pend;
    wr(1, 5); wr(0, 3);
    chk("R7 irq", irq, 1);
    chk("R7 set wins over clear", pending, 1);
    step; wr(0, 3);
    chk("R7 clear later", pending, 0);
  endtask

  task automatic t_late_enable;
    wr(0, 0); wr(1, 5);
    step; chk("R5 disabled", irq, 0);
    wr(0, 1);
    chk("R5 not yet", irq, 0);
    step; chk("R5 fires after enable", irq, 1);
  endtask

  initial begin
    step; step; rst_n = 1; step;
    t_reset; t_regs; t_disabled; t_equal; t_fire;
    t_targets; t_race_best; t_race_pend; t_late_enable;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule